// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block turns an asynchronous serial line into parallel characters. An external rate generator supplies a one-cycle `sampleTick` enable. The receiver counts these ticks to time each bit. A baud factor chooses how many ticks make one bit time: 1, 16 or 64. A falling edge on the line starts a character. The receiver then samples 5 to 8 data bits, an optional parity bit and one stop bit. It moves the finished character into a holding register and raises `rxReady`.

The CPU side works on the levels of `rxReady` and the three error flags, together with two single-cycle strobes. `rdStrobe` marks a data read and lowers `rxReady`. `errClear` clears the error flags. A character that completes before the previous one has been read replaces it and sets the overrun flag. Only one stop bit is checked, whatever stop length the transmitter uses.

Top module: `async_char_rx`

## Requirements
- R1: When idle, a high-to-low change of the line seen on a sample tick starts a character. With factor 16 or 64, the line is tested again half a bit time later. If it is high then, the receiver drops the attempt and returns to idle without loading anything.
- R2: Data bits are sampled once per bit time, at mid-bit, least significant bit first. The character length is 5 + `charLen` bits. `rxData` holds the character right-justified, with unused upper bits zero.
- R3: `baudSel` encodes the bit time in ticks: 0 gives 1 tick, 1 gives 16 ticks, and 2 or 3 give 64 ticks.
- R4: With `parityEn` = 1, one parity bit follows the data. `parityOdd` = 0 expects even parity and 1 expects odd parity, counting data and parity ones together. A mismatch sets `parityErr`. With `parityEn` = 0, no parity bit is expected.
- R5: A single stop bit is sampled. A low stop bit sets `frameErr`, and the character is still loaded.
- R6: The clock cycle after the stop bit is sampled, `rxData` holds the new character and `rxReady` is 1. `rxData` changes at no other time.
- R7: A one-cycle `rdStrobe` lowers `rxReady` on the next cycle, unless a character loads in that same cycle.
- R8: If a character loads while `rxReady` is 1 and no read is strobed, the new character replaces the old one and `overrunErr` is set.
- R9: The error flags stay set until a one-cycle `errClear`, which clears all three on the next cycle. A flag raised in that same cycle wins over the clear.
- R10: After reset, `rxReady`, `rxData` and all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleTick | input | 1 | One-cycle enable at the oversampling rate |
| rxLine | input | 1 | Serial receive line, high when idle |
| baudSel | input | 2 | Baud factor select (R3) |
| charLen | input | 2 | Character length minus 5 |
| parityEn | input | 1 | Parity bit present |
| parityOdd | input | 1 | 1 = odd parity, 0 = even parity |
| rdStrobe | input | 1 | CPU data read strobe |
| errClear | input | 1 | Clear all error flags |
| rxData | output | 8 | Received character holding register |
| rxReady | output | 1 | A character is waiting to be read |
| parityErr | output | 1 | Sticky parity error flag |
| frameErr | output | 1 | Sticky framing error flag |
| overrunErr | output | 1 | Sticky overrun error flag |

## Verification
Random characters are drawn across all three baud factors, all four lengths and all three parity settings, with an occasional bad parity bit or low stop bit. A wrong bit order, a wrong length alignment or a sampling point off mid-bit shows up as a data mismatch. Injected errors separate the parity check from the stop check. Directed cases cover the rest:
- a short start glitch at factor 16, which must leave nothing behind and must not disturb the next character;
- two unread characters in a row, for overrun and replacement;
- a framing error followed by a clean character, to show the flag is sticky;
- a read strobe and a clear strobe, each checked on its own.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
  // Strobes passed from bit-timing control to the character datapath
  typedef struct packed {
    logic clearShift;  // a confirmed start: reset shift register and parity
    logic dataBit;     // sample a data bit
    logic parBit;      // sample the parity bit
    logic stopBit;     // sample the stop bit and load the character
    logic lineVal;     // synchronized line value at this sample
  } rxStrobe_t;
endpackage

// File: rtl/async_rx_ctrl.sv
module async_rx_ctrl #(
  parameter int MAX_FACTOR = 64,
  parameter int DATA_MAX   = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sampleTick,
  input  logic                    rxLine,
  input  logic [1:0]              baudSel,
  input  logic [1:0]              charLen,
  input  logic                    parityEn,
  output async_rx_pkg::rxStrobe_t stb
);
  localparam int CNT_W = $clog2(MAX_FACTOR);
  localparam int BIT_W = $clog2(DATA_MAX);
  localparam int MIN_LEN = DATA_MAX - 3;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} rxState_t;

  rxState_t state;
  logic lineS1, lineS2, lastLine;
  logic [CNT_W-1:0] tickCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [CNT_W-1:0] fullM1, halfM1;
  logic [BIT_W-1:0] lenM1;
  logic bitEnd, halfEnd, startSeen;

  // Bit-time limits for each baud factor
  always_comb begin
    unique case (baudSel)
      2'd0:    begin fullM1 = CNT_W'(0);  halfM1 = CNT_W'(0); end
      2'd1:    begin fullM1 = CNT_W'(15); halfM1 = CNT_W'(7); end
      default: begin fullM1 = CNT_W'(MAX_FACTOR - 1); halfM1 = CNT_W'(MAX_FACTOR/2 - 1); end
    endcase
    lenM1 = BIT_W'(MIN_LEN - 1) + BIT_W'(charLen);
  end

  assign bitEnd    = sampleTick && (tickCnt == fullM1);
  assign halfEnd   = sampleTick && (tickCnt == halfM1);
  assign startSeen = sampleTick && lastLine && !lineS2;

  always_comb begin
    stb = '0;
    stb.lineVal = lineS2;
    unique case (state)
      S_IDLE:  stb.clearShift = startSeen && (baudSel == 2'd0);
      S_START: stb.clearShift = halfEnd && !lineS2;
      S_DATA:  stb.dataBit    = bitEnd;
      S_PAR:   stb.parBit     = bitEnd;
      S_STOP:  stb.stopBit    = bitEnd;
      default: stb = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineS1   <= 1'b1;
      lineS2   <= 1'b1;
      lastLine <= 1'b1;
      state    <= S_IDLE;
      tickCnt  <= '0;
      bitCnt   <= '0;
    end else begin
      lineS1 <= rxLine;
      lineS2 <= lineS1;
      unique case (state)
        S_IDLE: if (sampleTick) begin
          lastLine <= lineS2;
          tickCnt  <= '0;
          bitCnt   <= '0;
          if (startSeen) state <= (baudSel == 2'd0) ? S_DATA : S_START;
        end
        S_START: if (sampleTick) begin
          if (halfEnd) begin
            tickCnt <= '0;
            if (lineS2) begin
              state    <= S_IDLE;
              lastLine <= 1'b1;
            end else begin
              state <= S_DATA;
            end
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        S_DATA: if (sampleTick) begin
          if (bitEnd) begin
            tickCnt <= '0;
            if (bitCnt == lenM1) begin
              bitCnt <= '0;
              state  <= parityEn ? S_PAR : S_STOP;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        S_PAR: if (sampleTick) begin
          if (bitEnd) begin
            tickCnt <= '0;
            state   <= S_STOP;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        S_STOP: if (sampleTick) begin
          if (bitEnd) begin
            tickCnt  <= '0;
            state    <= S_IDLE;
            lastLine <= lineS2;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/async_rx_dpath.sv
module async_rx_dpath #(
  parameter int DATA_MAX = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  async_rx_pkg::rxStrobe_t stb,
  input  logic [1:0]              charLen,
  input  logic                    parityEn,
  input  logic                    parityOdd,
  input  logic                    rdStrobe,
  input  logic                    errClear,
  output logic [DATA_MAX-1:0]     rxData,
  output logic                    rxReady,
  output logic                    parityErr,
  output logic                    frameErr,
  output logic                    overrunErr
);
  localparam int SH_W = $clog2(DATA_MAX);
  localparam int MAX_SHIFT = 3;

  logic [DATA_MAX-1:0] shiftReg, aligned;
  logic parAcc, parBad;
  logic [SH_W-1:0] shAmt;

  // Bits arrive LSB first at the top, so a short character sits high: right-justify it
  assign shAmt   = SH_W'(MAX_SHIFT) - SH_W'(charLen);
  assign aligned = shiftReg >> shAmt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg   <= '0;
      parAcc     <= 1'b0;
      parBad     <= 1'b0;
      rxData     <= '0;
      rxReady    <= 1'b0;
      parityErr  <= 1'b0;
      frameErr   <= 1'b0;
      overrunErr <= 1'b0;
    end else begin
      if (stb.clearShift) begin
        shiftReg <= '0;
        parAcc   <= 1'b0;
        parBad   <= 1'b0;
      end
      if (stb.dataBit) begin
        shiftReg <= {stb.lineVal, shiftReg[DATA_MAX-1:1]};
        parAcc   <= parAcc ^ stb.lineVal;
      end
      if (stb.parBit) parBad <= parAcc ^ stb.lineVal ^ parityOdd;
      if (stb.stopBit) begin
        rxData  <= aligned;
        rxReady <= 1'b1;
      end else if (rdStrobe) begin
        rxReady <= 1'b0;
      end
      overrunErr <= (overrunErr & ~errClear) | (stb.stopBit & rxReady & ~rdStrobe);
      frameErr   <= (frameErr & ~errClear) | (stb.stopBit & ~stb.lineVal);
      parityErr  <= (parityErr & ~errClear) | (stb.stopBit & parityEn & parBad);
    end
  end
endmodule

// File: rtl/async_char_rx.sv
module async_char_rx #(
  parameter int MAX_FACTOR = 64,
  parameter int DATA_MAX   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleTick,
  input  logic                rxLine,
  input  logic [1:0]          baudSel,
  input  logic [1:0]          charLen,
  input  logic                parityEn,
  input  logic                parityOdd,
  input  logic                rdStrobe,
  input  logic                errClear,
  output logic [DATA_MAX-1:0] rxData,
  output logic                rxReady,
  output logic                parityErr,
  output logic                frameErr,
  output logic                overrunErr
);
  async_rx_pkg::rxStrobe_t stb;

  async_rx_ctrl #(.MAX_FACTOR(MAX_FACTOR), .DATA_MAX(DATA_MAX)) ctrl_i (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .baudSel(baudSel), .charLen(charLen), .parityEn(parityEn), .stb(stb)
  );

  async_rx_dpath #(.DATA_MAX(DATA_MAX)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .charLen(charLen),
    .parityEn(parityEn), .parityOdd(parityOdd), .rdStrobe(rdStrobe),
    .errClear(errClear), .rxData(rxData), .rxReady(rxReady),
    .parityErr(parityErr), .frameErr(frameErr), .overrunErr(overrunErr)
  );
endmodule

// File: rtl/async_char_rx_checker.sv
module async_char_rx_checker #(
  parameter int DATA_MAX = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                rdStrobe,
  input logic                errClear,
  input logic                stopTick,
  input logic                stopVal,
  input logic [DATA_MAX-1:0] rxData,
  input logic                rxReady,
  input logic                parityErr,
  input logic                frameErr,
  input logic                overrunErr
);
  p_ready_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    stopTick |=> rxReady);

  p_data_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    !stopTick |=> $stable(rxData));

  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !stopTick) |=> !rxReady);

  p_overrun_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stopTick && rxReady && !rdStrobe) |=> overrunErr);

  p_err_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (errClear && !stopTick) |=> !(parityErr || frameErr || overrunErr));

  p_frame_on_low_stop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stopTick && !stopVal) |=> frameErr);
endmodule

bind async_char_rx async_char_rx_checker #(.DATA_MAX(DATA_MAX)) chk_i (
  .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .errClear(errClear),
  .stopTick(stb.stopBit), .stopVal(stb.lineVal), .rxData(rxData),
  .rxReady(rxReady), .parityErr(parityErr), .frameErr(frameErr),
  .overrunErr(overrunErr)
);

// File: tb/async_char_rx_tb_top.sv
`timescale 1ns/1ps
module async_char_rx_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleTick = 1'b0;
  logic rxLine = 1'b1;
  logic [1:0] baudSel = 2'd1;
  logic [1:0] charLen = 2'd3;
  logic parityEn = 1'b0;
  logic parityOdd = 1'b0;
  logic rdStrobe = 1'b0;
  logic errClear = 1'b0;
  logic [7:0] rxData;
  logic rxReady, parityErr, frameErr, overrunErr;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  async_char_rx dut_i (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .baudSel(baudSel), .charLen(charLen), .parityEn(parityEn),
    .parityOdd(parityOdd), .rdStrobe(rdStrobe), .errClear(errClear),
    .rxData(rxData), .rxReady(rxReady), .parityErr(parityErr),
    .frameErr(frameErr), .overrunErr(overrunErr)
  );

  // one tick every fourth clock
  initial forever begin
    repeat (3) @(negedge clk);
    sampleTick = 1'b1;
    @(negedge clk);
    sampleTick = 1'b0;
  end

  function automatic int factorOf(input logic [1:0] sel);
    return (sel == 2'd0) ? 1 : (sel == 2'd1) ? 16 : 64;
  endfunction

  function automatic logic [7:0] maskOf(input int len);
    return 8'((1 << len) - 1);
  endfunction

  function automatic logic parityFor(input logic [7:0] d, input int len, input logic odd);
    return (^(d & maskOf(len))) ^ odd;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitTick();
    @(posedge sampleTick);
    @(negedge clk);
  endtask

  // parMode: 0 none, 1 even, 2 odd
  task automatic sendChar(input logic [1:0] sel, input int len, input logic [7:0] d,
                          input int parMode, input logic badPar, input logic stopVal);
    int f;
    f = factorOf(sel);
    baudSel = sel;
    charLen = 2'(len - 5);
    parityEn = (parMode != 0);
    parityOdd = (parMode == 2);
    waitTick();
    rxLine = 1'b0;
    repeat (f) waitTick();
    for (int i = 0; i < len; i++) begin
      rxLine = d[i];
      repeat (f) waitTick();
    end
    if (parMode != 0) begin
      rxLine = parityFor(d, len, parMode == 2) ^ badPar;
      repeat (f) waitTick();
    end
    rxLine = stopVal;
    repeat (f) waitTick();
    rxLine = 1'b1;
    repeat (f + 2) waitTick();
  endtask

  task automatic pulseRead();
    @(negedge clk); rdStrobe = 1'b1;
    @(negedge clk); rdStrobe = 1'b0;
  endtask

  task automatic pulseClear();
    @(negedge clk); errClear = 1'b1;
    @(negedge clk); errClear = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired, all requirements unfinished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd7321));
    repeat (5) @(negedge clk);
    // R10 reset state
    chk("R10 rxReady", 32'(rxReady), 0);
    chk("R10 rxData", 32'(rxData), 0);
    chk("R10 flags", {parityErr, frameErr, overrunErr}, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R3 basic character, factor 16, 8 bits
    sendChar(2'd1, 8, 8'hA5, 0, 1'b0, 1'b1);
    chk("R6 rxReady after load", 32'(rxReady), 1);
    chk("R2 data 8-bit LSB first", 32'(rxData), 32'hA5);
    // R7 read clears ready
    pulseRead();
    @(negedge clk);
    chk("R7 read clears rxReady", 32'(rxReady), 0);

    // R1 start glitch at factor 16 is dropped
    waitTick(); rxLine = 1'b0;
    repeat (3) waitTick(); rxLine = 1'b1;
    repeat (40) waitTick();
    chk("R1 glitch loads nothing", 32'(rxReady), 0);
    chk("R1 glitch leaves data", 32'(rxData), 32'hA5);
    sendChar(2'd1, 6, 8'h2D, 0, 1'b0, 1'b1);
    chk("R1 char after glitch", 32'(rxData), 32'h2D);
    pulseRead();

    // R3 factor 64 and R4 odd parity, 5 bits
    sendChar(2'd2, 5, 8'h13, 2, 1'b0, 1'b1);
    chk("R3 x64 data", 32'(rxData), 32'h13);
    chk("R4 odd parity ok", 32'(parityErr), 0);
    pulseRead();

    // R8 overrun: two unread characters
    sendChar(2'd0, 8, 8'h3C, 0, 1'b0, 1'b1);
    chk("R8 first no overrun", 32'(overrunErr), 0);
    sendChar(2'd0, 8, 8'hC7, 0, 1'b0, 1'b1);
    chk("R8 overrun set", 32'(overrunErr), 1);
    chk("R8 new data replaces", 32'(rxData), 32'hC7);
    chk("R8 still ready", 32'(rxReady), 1);
    pulseRead();
    // R9 errClear
    pulseClear();
    @(negedge clk);
    chk("R9 clear flags", {parityErr, frameErr, overrunErr}, 0);

    // R5 framing error, then R9 sticky through a clean character
    sendChar(2'd1, 7, 8'h55, 1, 1'b0, 1'b0);
    chk("R5 frame error", 32'(frameErr), 1);
    chk("R5 data still loaded", 32'(rxData), 32'h55);
    pulseRead();
    sendChar(2'd1, 7, 8'h2A, 1, 1'b0, 1'b1);
    chk("R9 frame flag sticky", 32'(frameErr), 1);
    chk("R9 data after frame err", 32'(rxData), 32'h2A);
    pulseRead();
    pulseClear();

    // R4 bad even parity
    sendChar(2'd1, 8, 8'h81, 1, 1'b1, 1'b1);
    chk("R4 even parity mismatch", 32'(parityErr), 1);
    pulseRead();
    pulseClear();

    // random mix
    for (int n = 0; n < 40; n++) begin
      logic [1:0] sel;
      int len, pm;
      logic bp, sv;
      sel = 2'($urandom % 3);
      len = 5 + int'($urandom % 4);
      pm  = int'($urandom % 3);
      bp  = (pm != 0) && ($urandom % 6 == 0);
      sv  = ($urandom % 8 != 0);
      d   = 8'($urandom);
      sendChar(sel, len, d, pm, bp, sv);
      chk("R2 random data", 32'(rxData), 32'(d & maskOf(len)));
      chk("R6 random ready", 32'(rxReady), 1);
      chk("R4 random parity flag", 32'(parityErr), 32'(bp));
      chk("R5 random frame flag", 32'(frameErr), 32'(!sv));
      @(negedge clk); rdStrobe = 1'b1; errClear = 1'b1;
      @(negedge clk); rdStrobe = 1'b0; errClear = 1'b0;
      @(negedge clk);
      chk("R7 random read", 32'(rxReady), 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule